// File: doc/BRIEF.md
# Dual-Mode Processor Counter/Timer

This block is a per-processor timer that sits behind a four-word register window. It runs in one of two modes, and an external mode input selects which one. In counter mode it is a periodic limit counter. It runs all the time, wraps to zero when it reaches a programmed limit, sets a sticky reached flag and raises its interrupt. In user mode the same registers act as the high and low halves of a wide up-timer. Software loads this timer, starts it and stops it, and the timer never interrupts.

The count advances by one unit on each clock in which the tick enable input is high and the timer is running. One unit equals 512 in the visible register value, so bits 8:0 of every count read are zero. A system-level controller owns the mode register. When it changes the mode it drives the mode level and pulses the matching enter or leave strobe in the same cycle. The strobe forces the run, stop and count state that the new mode needs.

Register words, selected by `bus_addr`: 0 = limit (counter mode) or count high half (user mode); 1 = count (counter mode) or count low half (user mode); 2 = limit load that keeps the count; 3 = run status. Reads return data in the same cycle. Any side effect of an access takes place at the next clock edge.

Top module: `tmr_dual_mode`

## Requirements
- R1: After reset the mode is counter, the limit and the count are 0, the reached flag and `irq` are 0, and status reads as 1. Word 2 always reads as 0.
- R2: In counter mode, each tick adds one unit to a 22-bit count. Word 1 reads the count in bits 30:9 and the reached flag in bit 31, and bits 8:0 are zero.
- R3: In counter mode, a tick that would bring the count to the limit (word 0 bits 30:9) instead sets the count to 0, sets reached and raises `irq`. A limit of 0 runs free and wraps after 2^22-1 ticks.
- R4: In counter mode, reading word 0 returns the limit in bits 30:9 and clears reached and `irq`. Writing word 0 loads the limit from bits 30:9, clears the count and lowers `irq`, and leaves reached unchanged.
- R5: In counter mode, writing word 2 loads the limit and keeps the current count.
- R6: In counter mode, writes to word 1 and word 3 have no effect, and the timer stays running.
- R7: An enter-user strobe lowers `irq`, stops the timer (status reads 0), clears the count and reached, and keeps the stored counter limit.
- R8: In user mode the count is 54 bits wide. Word 0 reads count bits 53:23 in bits 30:0 with reached in bit 31. Word 1 reads count bits 22:0 in bits 31:9. Reads have no side effect.
- R9: In user mode, writing word 0 loads count bits 53:23 from data bits 30:0, and writing word 1 loads count bits 22:0 from data bits 31:9. Either write clears reached.
- R10: In user mode, writing word 3 sets the run state from data bit 0. The count changes only on ticks while running, and status reads the run state in bit 0.
- R11: In user mode, a tick at the all-ones count wraps it to 0 and sets reached. `irq` is never raised in user mode.
- R12: A leave-user strobe sets running, clears the count and reached, and resumes counter operation with the counter limit that was stored before. Word 2 writes made in user mode are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| tick_en | input | 1 | Count enable, sampled each clock |
| user_mode | input | 1 | Mode level: 1 = user timer, 0 = limit counter |
| enter_user | input | 1 | One-cycle strobe when the mode changes to user |
| leave_user | input | 1 | One-cycle strobe when the mode changes to counter |
| bus_sel | input | 1 | Register access in this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 2 | Word index 0 to 3 |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the same cycle as `bus_sel` |
| irq | output | 1 | Counter-mode interrupt, level |

## Verification
The assertions check on every cycle the properties that depend only on the current state:
- a quiet interrupt stays low in user mode;
- a stopped user timer holds its count;
- counter mode keeps running and ignores writes to the count word;
- the counter count only steps by one or wraps;
- each mode strobe leaves the exact run, interrupt and count state that R7 and R12 require;
- bits 8:0 of a count read are always zero.

Some behaviour shows only in the directed scenarios. This covers the limit value at which the counter wraps, and the way a limit read acknowledges the interrupt while a limit write keeps reached. It also covers the carry between the two user halves, the all-ones wrap in user mode, and the counter limit that survives a round trip through user mode.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

  // Word index inside the register window
  typedef enum logic [1:0] {
    W_LIM_HI  = 2'd0,
    W_CNT_LO  = 2'd1,
    W_LIMKEEP = 2'd2,
    W_STATUS  = 2'd3
  } tmr_word_e;

  // Decoded, mode-qualified register operations
  typedef struct packed {
    logic ctr_lim_wr;
    logic ctr_lim_rd;
    logic ctr_keep_wr;
    logic usr_hi_wr;
    logic usr_lo_wr;
    logic usr_stat_wr;
  } tmr_op_t;

endpackage

// File: rtl/tmr_decode.sv
module tmr_decode
  import tmr_pkg::*;
(
  input  logic       bus_sel,
  input  logic       bus_we,
  input  logic [1:0] bus_addr,
  input  logic       user_mode,
  output tmr_op_t    op
);

  tmr_word_e word;
  logic      wr;
  logic      rd;

  always_comb begin
    word = tmr_word_e'(bus_addr);
    wr   = bus_sel && bus_we;
    rd   = bus_sel && !bus_we;
    op   = '0;
    unique case (word)
      W_LIM_HI: begin
        op.ctr_lim_wr = wr && !user_mode;
        op.ctr_lim_rd = rd && !user_mode;
        op.usr_hi_wr  = wr && user_mode;
      end
      W_CNT_LO:  op.usr_lo_wr   = wr && user_mode;
      W_LIMKEEP: op.ctr_keep_wr = wr && !user_mode;
      W_STATUS:  op.usr_stat_wr = wr && user_mode;
      default:   op = '0;
    endcase
  end

endmodule

// File: rtl/tmr_count.sv
module tmr_count
  import tmr_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int SUB    = 9,
  parameter int CTR_W  = DATA_W - 1 - SUB,
  parameter int LO_W   = DATA_W - SUB,
  parameter int CNT_W  = 2 * DATA_W - 1 - SUB
) (
  input  logic              clk,
  input  logic              rst_sn,
  input  tmr_op_t           op,
  input  logic [DATA_W-1:0] wdata,
  input  logic              tick_en,
  input  logic              run_q,
  input  logic              user_mode,
  input  logic              enter_user,
  input  logic              leave_user,
  output logic [CNT_W-1:0]  cnt_q,
  output logic [CTR_W-1:0]  lim_q,
  output logic              wrap_evt
);

  localparam int EXT_W = CNT_W + 1;

  logic [CNT_W-1:0] cnt_d;
  logic [CTR_W-1:0] lim_d;
  logic [CTR_W-1:0] term;
  logic [EXT_W-1:0] nxt_ext;
  logic [EXT_W-1:0] term_ext;
  logic             advance;
  logic             hit;
  logic             override;
  logic             unused_ops;

  assign unused_ops = op.ctr_lim_rd ^ op.usr_stat_wr;

  always_comb begin
    advance  = tick_en && run_q;
    nxt_ext  = {1'b0, cnt_q} + EXT_W'(1);
    term     = (lim_q == '0) ? '1 : lim_q;
    term_ext = EXT_W'(term);
    hit      = user_mode ? (&cnt_q) : (nxt_ext >= term_ext);
    override = enter_user || leave_user || op.ctr_lim_wr ||
               op.usr_hi_wr || op.usr_lo_wr;
    wrap_evt = advance && hit && !override;

    cnt_d = cnt_q;
    if (enter_user || leave_user || op.ctr_lim_wr) begin
      cnt_d = '0;
    end else if (op.usr_hi_wr) begin
      cnt_d = {wdata[DATA_W-2:0], cnt_q[LO_W-1:0]};
    end else if (op.usr_lo_wr) begin
      cnt_d = {cnt_q[CNT_W-1:LO_W], wdata[DATA_W-1:SUB]};
    end else if (advance) begin
      cnt_d = hit ? '0 : nxt_ext[CNT_W-1:0];
    end

    lim_d = lim_q;
    if (op.ctr_lim_wr || op.ctr_keep_wr) begin
      lim_d = wdata[DATA_W-2:SUB];
    end
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      cnt_q <= '0;
      lim_q <= '0;
    end else begin
      cnt_q <= cnt_d;
      lim_q <= lim_d;
    end
  end

endmodule

// File: rtl/tmr_flags.sv
module tmr_flags
  import tmr_pkg::*;
(
  input  logic    clk,
  input  logic    rst_sn,
  input  tmr_op_t op,
  input  logic    stat_bit,
  input  logic    user_mode,
  input  logic    enter_user,
  input  logic    leave_user,
  input  logic    wrap_evt,
  output logic    reached_q,
  output logic    irq_q,
  output logic    run_q
);

  logic reached_d;
  logic irq_d;
  logic run_d;
  logic unused_ops;

  assign unused_ops = op.ctr_keep_wr;

  always_comb begin
    reached_d = reached_q;
    if (enter_user || leave_user) begin
      reached_d = 1'b0;
    end else if (wrap_evt) begin
      reached_d = 1'b1;
    end else if (op.usr_hi_wr || op.usr_lo_wr || op.ctr_lim_rd) begin
      reached_d = 1'b0;
    end

    irq_d = irq_q;
    if (enter_user) begin
      irq_d = 1'b0;
    end else if (wrap_evt && !user_mode) begin
      irq_d = 1'b1;
    end else if (op.ctr_lim_rd || op.ctr_lim_wr) begin
      irq_d = 1'b0;
    end

    run_d = run_q;
    if (enter_user) begin
      run_d = 1'b0;
    end else if (leave_user) begin
      run_d = 1'b1;
    end else if (op.usr_stat_wr) begin
      run_d = stat_bit;
    end
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      reached_q <= 1'b0;
      irq_q     <= 1'b0;
      run_q     <= 1'b1;
    end else begin
      reached_q <= reached_d;
      irq_q     <= irq_d;
      run_q     <= run_d;
    end
  end

endmodule

// File: rtl/tmr_rdmux.sv
module tmr_rdmux
  import tmr_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int SUB    = 9,
  parameter int CTR_W  = DATA_W - 1 - SUB,
  parameter int LO_W   = DATA_W - SUB,
  parameter int CNT_W  = 2 * DATA_W - 1 - SUB
) (
  input  logic              bus_sel,
  input  logic [1:0]        bus_addr,
  input  logic              user_mode,
  input  logic [CNT_W-1:0]  cnt_q,
  input  logic [CTR_W-1:0]  lim_q,
  input  logic              reached_q,
  input  logic              run_q,
  output logic [DATA_W-1:0] rdata
);

  always_comb begin
    rdata = '0;
    if (bus_sel) begin
      unique case (tmr_word_e'(bus_addr))
        W_LIM_HI: rdata = user_mode ? {reached_q, cnt_q[CNT_W-1:LO_W]}
                                    : {1'b0, lim_q, {SUB{1'b0}}};
        W_CNT_LO: rdata = user_mode ? {cnt_q[LO_W-1:0], {SUB{1'b0}}}
                                    : {reached_q, cnt_q[CTR_W-1:0], {SUB{1'b0}}};
        W_STATUS: rdata = {{(DATA_W-1){1'b0}}, run_q};
        default:  rdata = '0;
      endcase
    end
  end

endmodule

// File: rtl/tmr_dual_mode.sv
module tmr_dual_mode
  import tmr_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int SUB    = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_en,
  input  logic              user_mode,
  input  logic              enter_user,
  input  logic              leave_user,
  input  logic              bus_sel,
  input  logic              bus_we,
  input  logic [1:0]        bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq
);

  localparam int CTR_W = DATA_W - 1 - SUB;
  localparam int LO_W  = DATA_W - SUB;
  localparam int CNT_W = 2 * DATA_W - 1 - SUB;

  logic [1:0]       rst_pipe;
  logic             rst_sn;
  tmr_op_t          op;
  logic [CNT_W-1:0] cnt_q;
  logic [CTR_W-1:0] lim_q;
  logic             wrap_evt;
  logic             reached_q;
  logic             run_q;

  // Assert asynchronously, release on the clock
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe <= 2'b00;
    end else begin
      rst_pipe <= {rst_pipe[0], 1'b1};
    end
  end
  assign rst_sn = rst_pipe[1];

  tmr_decode u_dec (
    .bus_sel   (bus_sel),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .user_mode (user_mode),
    .op        (op)
  );

  tmr_count #(
    .DATA_W (DATA_W), .SUB (SUB), .CTR_W (CTR_W), .LO_W (LO_W), .CNT_W (CNT_W)
  ) u_cnt (
    .clk        (clk),
    .rst_sn     (rst_sn),
    .op         (op),
    .wdata      (bus_wdata),
    .tick_en    (tick_en),
    .run_q      (run_q),
    .user_mode  (user_mode),
    .enter_user (enter_user),
    .leave_user (leave_user),
    .cnt_q      (cnt_q),
    .lim_q      (lim_q),
    .wrap_evt   (wrap_evt)
  );

  tmr_flags u_flg (
    .clk        (clk),
    .rst_sn     (rst_sn),
    .op         (op),
    .stat_bit   (bus_wdata[0]),
    .user_mode  (user_mode),
    .enter_user (enter_user),
    .leave_user (leave_user),
    .wrap_evt   (wrap_evt),
    .reached_q  (reached_q),
    .irq_q      (irq),
    .run_q      (run_q)
  );

  tmr_rdmux #(
    .DATA_W (DATA_W), .SUB (SUB), .CTR_W (CTR_W), .LO_W (LO_W), .CNT_W (CNT_W)
  ) u_rd (
    .bus_sel   (bus_sel),
    .bus_addr  (bus_addr),
    .user_mode (user_mode),
    .cnt_q     (cnt_q),
    .lim_q     (lim_q),
    .reached_q (reached_q),
    .run_q     (run_q),
    .rdata     (bus_rdata)
  );

endmodule

// File: rtl/tmr_dual_mode_chk.sv
module tmr_dual_mode_chk #(
  parameter int DATA_W = 32,
  parameter int SUB    = 9,
  parameter int CNT_W  = 54
) (
  input logic              clk,
  input logic              rst_sn,
  input logic              tick_en,
  input logic              user_mode,
  input logic              enter_user,
  input logic              leave_user,
  input logic              bus_sel,
  input logic              bus_we,
  input logic [1:0]        bus_addr,
  input logic [DATA_W-1:0] bus_rdata,
  input logic              irq,
  input logic              run_q,
  input logic [CNT_W-1:0]  cnt_q
);

  logic any_wr;
  assign any_wr = bus_sel && bus_we;

  p_count_lsb_zero_r2: assert property (@(posedge clk) disable iff (!rst_sn)
    (bus_sel && !bus_we && bus_addr == 2'd1) |-> (bus_rdata[SUB-1:0] == '0));

  p_ctr_step_r3: assert property (@(posedge clk) disable iff (!rst_sn)
    (!user_mode && tick_en && run_q && !enter_user && !leave_user && !any_wr)
    |=> (cnt_q == $past(cnt_q) + CNT_W'(1) || cnt_q == '0));

  p_ctr_lo_ignored_r6: assert property (@(posedge clk) disable iff (!rst_sn)
    (!user_mode && any_wr && bus_addr == 2'd1 && !tick_en && !enter_user && !leave_user)
    |=> $stable(cnt_q));

  p_ctr_keeps_running_r6: assert property (@(posedge clk) disable iff (!rst_sn)
    (!user_mode && run_q && !enter_user) |=> run_q);

  p_enter_state_r7: assert property (@(posedge clk) disable iff (!rst_sn)
    enter_user |=> (!run_q && !irq && cnt_q == '0));

  p_stopped_holds_r10: assert property (@(posedge clk) disable iff (!rst_sn)
    (user_mode && !run_q && !enter_user && !leave_user && !any_wr) |=> $stable(cnt_q));

  p_user_no_irq_r11: assert property (@(posedge clk) disable iff (!rst_sn)
    (user_mode && !irq) |=> !irq);

  p_leave_state_r12: assert property (@(posedge clk) disable iff (!rst_sn)
    leave_user |=> (run_q && cnt_q == '0));

endmodule

bind tmr_dual_mode tmr_dual_mode_chk #(
  .DATA_W (DATA_W), .SUB (SUB), .CNT_W (CNT_W)
) u_chk (
  .clk        (clk),
  .rst_sn     (rst_sn),
  .tick_en    (tick_en),
  .user_mode  (user_mode),
  .enter_user (enter_user),
  .leave_user (leave_user),
  .bus_sel    (bus_sel),
  .bus_we     (bus_we),
  .bus_addr   (bus_addr),
  .bus_rdata  (bus_rdata),
  .irq        (irq),
  .run_q      (run_q),
  .cnt_q      (cnt_q)
);

// File: tb/tb_tmr_dual_mode.sv
module tb_tmr_dual_mode;

  localparam int CLK_PERIOD = 10;

  logic        clk;
  logic        rst_n;
  logic        tick_en;
  logic        user_mode;
  logic        enter_user;
  logic        leave_user;
  logic        bus_sel;
  logic        bus_we;
  logic [1:0]  bus_addr;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic        irq;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  tmr_dual_mode dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick_en    (tick_en),
    .user_mode  (user_mode),
    .enter_user (enter_user),
    .leave_user (leave_user),
    .bus_sel    (bus_sel),
    .bus_we     (bus_we),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .bus_rdata  (bus_rdata),
    .irq        (irq)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_we = 1'b0;
  endtask

  task automatic rd_chk(input string req, input logic [1:0] a, input logic [31:0] exp);
    logic [31:0] got;
    @(negedge clk);
    bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a;
    #1 got = bus_rdata;
    @(negedge clk);
    bus_sel = 1'b0;
    chk(req, got, exp);
  endtask

  task automatic ticks(input int n);
    @(negedge clk);
    tick_en = 1'b1;
    repeat (n) @(negedge clk);
    tick_en = 1'b0;
  endtask

  task automatic go_user();
    @(negedge clk);
    user_mode = 1'b1; enter_user = 1'b1;
    @(negedge clk);
    enter_user = 1'b0;
  endtask

  task automatic go_counter();
    @(negedge clk);
    user_mode = 1'b0; leave_user = 1'b1;
    @(negedge clk);
    leave_user = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1 irq", {31'b0, irq}, 32'h0);
    rd_chk("R1 limit", 2'd0, 32'h0);
    rd_chk("R1 count", 2'd1, 32'h0);
    rd_chk("R1 status", 2'd3, 32'h1);
    rd_chk("R1 word2", 2'd2, 32'h0);
  endtask

  task automatic t_ctr_limit();
    wr(2'd0, 32'h8000_0A00);              // limit 5, bit 31 dropped
    ticks(4);
    rd_chk("R2 count 4", 2'd1, 32'h0000_0800);
    chk("R3 no irq early", {31'b0, irq}, 32'h0);
    ticks(1);
    chk("R3 irq at limit", {31'b0, irq}, 32'h1);
    rd_chk("R3 wrap+reached", 2'd1, 32'h8000_0000);
    rd_chk("R4 limit read", 2'd0, 32'h0000_0A00);
    chk("R4 irq acked", {31'b0, irq}, 32'h0);
    rd_chk("R4 reached cleared", 2'd1, 32'h0);
  endtask

  task automatic t_ctr_keep();
    ticks(3);
    wr(2'd2, 32'h0000_1400);              // limit 10, count kept
    rd_chk("R5 count kept", 2'd1, 32'h0000_0600);
    wr(2'd1, 32'hFFFF_FE00);
    rd_chk("R6 count write ignored", 2'd1, 32'h0000_0600);
    wr(2'd3, 32'h0);
    rd_chk("R6 status write ignored", 2'd3, 32'h1);
    ticks(6);
    rd_chk("R5 count 9", 2'd1, 32'h0000_1200);
    chk("R5 no irq before 10", {31'b0, irq}, 32'h0);
    ticks(1);
    chk("R5 irq at new limit", {31'b0, irq}, 32'h1);
    wr(2'd0, 32'h0000_1400);
    chk("R4 write lowers irq", {31'b0, irq}, 32'h0);
    rd_chk("R4 write keeps reached", 2'd1, 32'h8000_0000);
    rd_chk("R4 limit readback", 2'd0, 32'h0000_1400);
    rd_chk("R4 acked", 2'd1, 32'h0);
  endtask

  task automatic t_freerun();
    wr(2'd0, 32'h0);
    ticks(3);
    rd_chk("R3 zero limit runs", 2'd1, 32'h0000_0600);
    chk("R3 zero limit no irq", {31'b0, irq}, 32'h0);
    wr(2'd0, 32'h0000_0600);              // limit 3
  endtask

  task automatic t_enter();
    ticks(3);
    chk("R3 irq before enter", {31'b0, irq}, 32'h1);
    go_user();
    chk("R7 irq lowered", {31'b0, irq}, 32'h0);
    rd_chk("R7 stopped", 2'd3, 32'h0);
    rd_chk("R7 high cleared", 2'd0, 32'h0);
    rd_chk("R7 low cleared", 2'd1, 32'h0);
    ticks(4);
    rd_chk("R10 stopped holds", 2'd1, 32'h0);
  endtask

  task automatic t_user_load();
    wr(2'd0, 32'h0000_0001);
    wr(2'd1, 32'hFFFF_FC00);
    rd_chk("R9 high load", 2'd0, 32'h0000_0001);
    rd_chk("R8 low read", 2'd1, 32'hFFFF_FC00);
    wr(2'd3, 32'h1);
    rd_chk("R10 started", 2'd3, 32'h1);
    ticks(3);
    rd_chk("R8 carry into high", 2'd0, 32'h0000_0002);
    rd_chk("R8 low after carry", 2'd1, 32'h0000_0200);
    chk("R11 no irq user", {31'b0, irq}, 32'h0);
    wr(2'd3, 32'h0);
    ticks(2);
    rd_chk("R10 stop holds low", 2'd1, 32'h0000_0200);
    rd_chk("R10 status stopped", 2'd3, 32'h0);
    wr(2'd2, 32'h0000_0E00);              // ignored in user mode
  endtask

  task automatic t_user_wrap();
    wr(2'd0, 32'hFFFF_FFFF);
    wr(2'd1, 32'hFFFF_FE00);
    rd_chk("R9 high masked", 2'd0, 32'h7FFF_FFFF);
    wr(2'd3, 32'h1);
    ticks(1);
    rd_chk("R11 reached on wrap", 2'd0, 32'h8000_0000);
    rd_chk("R8 read no side effect", 2'd0, 32'h8000_0000);
    rd_chk("R11 low wrapped", 2'd1, 32'h0);
    chk("R11 no irq on wrap", {31'b0, irq}, 32'h0);
    wr(2'd1, 32'h0);
    rd_chk("R9 write clears reached", 2'd0, 32'h0);
    wr(2'd3, 32'h0);
  endtask

  task automatic t_leave();
    go_counter();
    rd_chk("R12 running", 2'd3, 32'h1);
    rd_chk("R12 count cleared", 2'd1, 32'h0);
    rd_chk("R12 limit kept", 2'd0, 32'h0000_0600);
    ticks(2);
    rd_chk("R12 counting", 2'd1, 32'h0000_0400);
    ticks(1);
    chk("R12 irq at kept limit", {31'b0, irq}, 32'h1);
  endtask

  initial begin
    rst_n = 1'b0; tick_en = 1'b0; user_mode = 1'b0;
    enter_user = 1'b0; leave_user = 1'b0;
    bus_sel = 1'b0; bus_we = 1'b0; bus_addr = 2'd0; bus_wdata = 32'h0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    t_ctr_limit();
    t_ctr_keep();
    t_freerun();
    t_enter();
    t_user_load();
    t_user_wrap();
    t_leave();
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      total++;
      bad++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule